// File: doc/BRIEF.md
# PLL Charge-Pump Holdover Controller

This block decides when the charge pump of a phase-locked loop is switched to high impedance, so that the oscillator keeps roughly its last frequency once the reference clock is lost. It runs in the phase-detector clock domain. Holdover can be entered in two ways. In manual mode a falling edge on an active-low synchronisation input starts it. In automatic mode it starts when a qualified digital lock indication drops after lock had been reached.

Entry follows the triggering event after a short, fixed latency. Release only happens on a reference edge at the phase detector. In the same cycle as that release, a one-cycle reset is sent to the feedback B-counter. The R and N counters are never stopped by this block.

After an automatic release, the controller will not trigger again until lock has been qualified anew. The digital lock indication comes from an internal counter. It asserts after a programmable number of consecutive in-window cycles. A calibration request made while holdover is enabled is refused and flagged.

Top module: `hold_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `cp_hiz`, `bcnt_rst`, `lock_det`, `rearm_pend`, `cal_start` and `cal_err` are all 0.
- R2: Holdover is active only when `hold_en_a` and `hold_en_b` are both 1. With either bit at 0, neither a SYNC fall nor a loss of lock raises `cp_hiz`. Clearing either bit during holdover drops `cp_hiz` at the next rising edge, with no `bcnt_rst` pulse.
- R3: A high-to-low transition of `sync_n` raises `cp_hiz` at the third rising clock edge after the new level is applied: two synchroniser flops, then the state register. A `sync_n` that is already low when holdover becomes enabled does not trigger entry.
- R4: A manual holdover lasts while the synchronised `sync_n` is low, and `ref_edge` pulses during that time do nothing. Once `sync_n` is high, `cp_hiz` stays 1 until a rising edge at which `ref_edge` is 1. At that edge `cp_hiz` goes to 0 and `bcnt_rst` is 1 for exactly one cycle.
- R5: `lock_det` rises at the rising edge that samples the N-th consecutive cycle with `win_ok` = 1. N is `lock_cnt_cfg`, raised to 5 when the setting is below 5. Any cycle with `win_ok` = 0 clears `lock_det` at that edge and restarts the count.
- R6: With `auto_en` = 1, a 1-to-0 change of `lock_det` raises `cp_hiz` one edge later, provided the effective analog lock is 1. With `auto_en` = 0, loss of lock never raises `cp_hiz`.
- R7: The effective analog lock depends on `alock_use`. When `alock_use` = 1 it is `alock_lvl` passed through two synchroniser flops. When `alock_use` = 0 it is always 1.
- R8: An automatic holdover is released at the first edge where `ref_edge` = 1, and `bcnt_rst` pulses at that edge. `rearm_pend` is then 1 and no further automatic entry can happen until `lock_det` is 1 again. `rearm_pend` clears one edge after `lock_det` rises.
- R9: When `cal_req` is sampled with holdover enabled, `cal_err` pulses for one cycle on the next edge and `cal_start` stays 0. When holdover is disabled, `cal_start` pulses instead and `cal_err` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase-detector clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_en_a | input | 1 | First holdover enable bit |
| hold_en_b | input | 1 | Second holdover enable bit |
| auto_en | input | 1 | Enables entry on loss of lock |
| alock_use | input | 1 | 1: use the analog lock level, 0: treat it as high |
| alock_lvl | input | 1 | Analog lock-detect level (asynchronous) |
| sync_n | input | 1 | Active-low manual holdover request (asynchronous) |
| ref_edge | input | 1 | One-cycle strobe marking a reference edge at the phase detector |
| win_ok | input | 1 | Reference and feedback inside the lock window this cycle |
| lock_cnt_cfg | input | LCNT_W | Required count of consecutive in-window cycles |
| cal_req | input | 1 | Oscillator calibration request strobe |
| cp_hiz | output | 1 | Charge pump forced to high impedance |
| bcnt_rst | output | 1 | One-cycle feedback B-counter reset |
| lock_det | output | 1 | Qualified digital lock indication |
| rearm_pend | output | 1 | Automatic holdover released and waiting for lock |
| cal_start | output | 1 | Accepted calibration request pulse |
| cal_err | output | 1 | Refused calibration request pulse |

## Verification
The assertions assume the following about the inputs:
- `ref_edge`, `win_ok` and `cal_req` are synchronous to `clk`, and `ref_edge` and `cal_req` are single-cycle strobes.
- `lock_cnt_cfg` stays constant while a lock count is in progress.
- The asynchronous inputs `sync_n` and `alock_lvl` change only rarely compared with the clock.

The directed stimulus keeps to these assumptions. It changes every input half a period away from the sampling edge. It holds the count setting steady before each qualification run. It leaves `sync_n` and `alock_lvl` unchanged for several cycles after each change, so that the synchronisers have settled before any result is sampled.

// File: rtl/hold_pkg.sv
package hold_pkg;

  typedef enum logic [2:0] {
    ST_RUN       = 3'd0,
    ST_MAN_HOLD  = 3'd1,
    ST_MAN_WAIT  = 3'd2,
    ST_AUTO_HOLD = 3'd3,
    ST_REARM     = 3'd4
  } hold_st_e;

  localparam int unsigned LOCK_MIN = 5;

  // effective qualification length: programmed value, never below the floor
  function automatic int unsigned lock_target(input int unsigned cfg);
    return (cfg < LOCK_MIN) ? LOCK_MIN : cfg;
  endfunction

  function automatic logic drives_hiz(input hold_st_e s);
    return (s == ST_MAN_HOLD) || (s == ST_MAN_WAIT) || (s == ST_AUTO_HOLD);
  endfunction

  function automatic logic alock_eff(input logic use_lvl, input logic lvl);
    return use_lvl ? lvl : 1'b1;
  endfunction

endpackage

// File: rtl/hold_sync.sv
module hold_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= {STAGES{RST_VAL}};
    else        sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/hold_lockq.sv
module hold_lockq
  import hold_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_ok,
  input  logic [CNT_W-1:0] cfg,
  output logic             dld
);
  localparam int TW = CNT_W + 1;

  logic [CNT_W-1:0] cnt;
  logic [TW-1:0]    cnt_inc;
  logic [TW-1:0]    tgt;
  logic             reached;

  assign cnt_inc = {1'b0, cnt} + 1'b1;
  assign tgt     = TW'(lock_target(32'(cfg)));
  assign reached = (cnt_inc >= tgt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      dld <= 1'b0;
    end else if (!win_ok) begin
      cnt <= '0;
      dld <= 1'b0;
    end else begin
      dld <= reached;
      if (!reached) cnt <= cnt_inc[CNT_W-1:0];
    end
  end

  // R5
  win_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_ok |=> !dld);

  // R5
  dld_needs_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dld) |-> $past(win_ok));
endmodule

// File: rtl/hold_fsm.sv
module hold_fsm
  import hold_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hold_on,
  input  logic auto_on,
  input  logic sync_lvl,
  input  logic alock_ok,
  input  logic ref_edge,
  input  logic dld,
  input  logic cal_req,
  output logic cp_hiz,
  output logic bcnt_rst,
  output logic rearm_pend,
  output logic cal_start,
  output logic cal_err
);
  hold_st_e st, st_n;
  logic     sync_prev, dld_prev;
  logic     sync_fall, dld_fall, auto_trig, release_evt;

  assign sync_fall = sync_prev & ~sync_lvl;
  assign dld_fall  = dld_prev & ~dld;
  assign auto_trig = auto_on & dld_fall & alock_ok;

  always_comb begin
    st_n        = st;
    release_evt = 1'b0;
    if (!hold_on) begin
      st_n = ST_RUN;
    end else if (sync_fall) begin
      st_n = ST_MAN_HOLD;
    end else begin
      unique case (st)
        ST_RUN:       if (auto_trig) st_n = ST_AUTO_HOLD;
        ST_MAN_HOLD:  if (sync_lvl)  st_n = ST_MAN_WAIT;
        ST_MAN_WAIT:  if (ref_edge) begin
                        st_n        = ST_RUN;
                        release_evt = 1'b1;
                      end
        ST_AUTO_HOLD: if (ref_edge) begin
                        st_n        = ST_REARM;
                        release_evt = 1'b1;
                      end
        ST_REARM:     if (dld || !auto_on) st_n = ST_RUN;
        default:      st_n = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_RUN;
      sync_prev  <= 1'b1;
      dld_prev   <= 1'b0;
      cp_hiz     <= 1'b0;
      bcnt_rst   <= 1'b0;
      rearm_pend <= 1'b0;
      cal_start  <= 1'b0;
      cal_err    <= 1'b0;
    end else begin
      st         <= st_n;
      sync_prev  <= sync_lvl;
      dld_prev   <= dld;
      cp_hiz     <= drives_hiz(st_n);
      bcnt_rst   <= release_evt;
      rearm_pend <= (st_n == ST_REARM);
      cal_start  <= cal_req & ~hold_on;
      cal_err    <= cal_req & hold_on;
    end
  end

  // R2
  disable_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_on |=> (!cp_hiz && !bcnt_rst));

  // R3
  sync_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_fall && hold_on) |=> cp_hiz);

  // R4
  bcnt_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bcnt_rst |-> ($past(cp_hiz) && !cp_hiz));

  // R4
  hiz_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_hiz && hold_on && !ref_edge) |=> cp_hiz);

  // R6
  auto_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_trig && hold_on) |=> cp_hiz);

  // R8
  rearm_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rearm_pend |-> !cp_hiz);

  // R9
  cal_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_req && hold_on) |=> (cal_err && !cal_start));

  // R9
  cal_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cal_err && cal_start));
endmodule

// File: rtl/hold_ctrl.sv
module hold_ctrl
  import hold_pkg::*;
#(
  parameter int LCNT_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_en_a,
  input  logic              hold_en_b,
  input  logic              auto_en,
  input  logic              alock_use,
  input  logic              alock_lvl,
  input  logic              sync_n,
  input  logic              ref_edge,
  input  logic              win_ok,
  input  logic [LCNT_W-1:0] lock_cnt_cfg,
  input  logic              cal_req,
  output logic              cp_hiz,
  output logic              bcnt_rst,
  output logic              lock_det,
  output logic              rearm_pend,
  output logic              cal_start,
  output logic              cal_err
);
  logic hold_on;
  logic sync_lvl;
  logic alock_s;
  logic alock_ok;

  assign hold_on  = hold_en_a & hold_en_b;
  assign alock_ok = alock_eff(alock_use, alock_s);

  hold_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sync (
    .clk(clk), .rst_n(rst_n), .d(sync_n), .q(sync_lvl));

  hold_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_alock_sync (
    .clk(clk), .rst_n(rst_n), .d(alock_lvl), .q(alock_s));

  hold_lockq #(.CNT_W(LCNT_W)) u_lockq (
    .clk(clk), .rst_n(rst_n), .win_ok(win_ok), .cfg(lock_cnt_cfg), .dld(lock_det));

  hold_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .hold_on(hold_on), .auto_on(auto_en),
    .sync_lvl(sync_lvl), .alock_ok(alock_ok), .ref_edge(ref_edge),
    .dld(lock_det), .cal_req(cal_req), .cp_hiz(cp_hiz), .bcnt_rst(bcnt_rst),
    .rearm_pend(rearm_pend), .cal_start(cal_start), .cal_err(cal_err));
endmodule

// File: tb/hold_ctrl_bench.sv
`timescale 1ns/1ps
module hold_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hold_en_a = 1'b0, hold_en_b = 1'b0, auto_en = 1'b0;
  logic       alock_use = 1'b0, alock_lvl = 1'b0, sync_n = 1'b1;
  logic       ref_edge = 1'b0, win_ok = 1'b0, cal_req = 1'b0;
  logic [7:0] lock_cnt_cfg = 8'd5;
  logic       cp_hiz, bcnt_rst, lock_det, rearm_pend, cal_start, cal_err;
  int         n_vec = 0, n_bad = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  hold_ctrl u_hold_ctrl (
    .clk(clk), .rst_n(rst_n), .hold_en_a(hold_en_a), .hold_en_b(hold_en_b),
    .auto_en(auto_en), .alock_use(alock_use), .alock_lvl(alock_lvl),
    .sync_n(sync_n), .ref_edge(ref_edge), .win_ok(win_ok),
    .lock_cnt_cfg(lock_cnt_cfg), .cal_req(cal_req), .cp_hiz(cp_hiz),
    .bcnt_rst(bcnt_rst), .lock_det(lock_det), .rearm_pend(rearm_pend),
    .cal_start(cal_start), .cal_err(cal_err));

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic pulse_ref();
    ref_edge = 1'b1; step(1); ref_edge = 1'b0;
  endtask

  task automatic t_reset();
    step(3);
    chk("R1", "cp_hiz in reset", cp_hiz, 1'b0);
    chk("R1", "bcnt_rst in reset", bcnt_rst, 1'b0);
    chk("R1", "lock_det in reset", lock_det, 1'b0);
    rst_n = 1'b1; step(1);
    chk("R1", "cp_hiz after reset", cp_hiz, 1'b0);
    chk("R1", "rearm_pend after reset", rearm_pend, 1'b0);
    chk("R1", "cal_start after reset", cal_start, 1'b0);
    chk("R1", "cal_err after reset", cal_err, 1'b0);
  endtask

  task automatic t_manual();
    hold_en_a = 1'b1; hold_en_b = 1'b1; auto_en = 1'b0; step(4);
    sync_n = 1'b0; step(2);
    chk("R3", "hiz before 3rd edge", cp_hiz, 1'b0);
    step(1);
    chk("R3", "hiz at 3rd edge", cp_hiz, 1'b1);
    pulse_ref();
    chk("R4", "ref edge while sync low ignored", cp_hiz, 1'b1);
    chk("R4", "no bcnt while sync low", bcnt_rst, 1'b0);
    sync_n = 1'b1; step(6);
    chk("R4", "hiz waits for ref edge", cp_hiz, 1'b1);
    pulse_ref();
    chk("R4", "released on ref edge", cp_hiz, 1'b0);
    chk("R4", "bcnt pulse on release", bcnt_rst, 1'b1);
    step(1);
    chk("R4", "bcnt single cycle", bcnt_rst, 1'b0);
  endtask

  task automatic t_disable();
    hold_en_b = 1'b0; step(2);
    sync_n = 1'b0; step(4);
    chk("R2", "en_b clear blocks sync", cp_hiz, 1'b0);
    sync_n = 1'b1; step(4);
    hold_en_a = 1'b0; hold_en_b = 1'b1; step(2);
    sync_n = 1'b0; step(4);
    chk("R2", "en_a clear blocks sync", cp_hiz, 1'b0);
    sync_n = 1'b1; step(4);
    hold_en_a = 1'b1; step(2);
    sync_n = 1'b0; step(3);
    chk("R2", "entry with both enables", cp_hiz, 1'b1);
    hold_en_b = 1'b0; step(1);
    chk("R2", "disable releases at once", cp_hiz, 1'b0);
    chk("R2", "no bcnt on disable", bcnt_rst, 1'b0);
    hold_en_b = 1'b1; step(5);
    chk("R3", "low level alone no entry", cp_hiz, 1'b0);
    sync_n = 1'b1; step(4);
  endtask

  task automatic t_lockq();
    auto_en = 1'b0;
    lock_cnt_cfg = 8'd3; win_ok = 1'b1; step(4);
    chk("R5", "floor 5: not yet at 4", lock_det, 1'b0);
    step(1);
    chk("R5", "floor 5: lock at 5", lock_det, 1'b1);
    step(3);
    chk("R5", "lock holds", lock_det, 1'b1);
    win_ok = 1'b0; step(1);
    chk("R5", "drop on out-of-window", lock_det, 1'b0);
    win_ok = 1'b1; step(4);
    chk("R5", "count restarted", lock_det, 1'b0);
    step(1);
    chk("R5", "relock after 5", lock_det, 1'b1);
    win_ok = 1'b0; step(1);
    lock_cnt_cfg = 8'd12; win_ok = 1'b1; step(11);
    chk("R5", "cfg 12: not at 11", lock_det, 1'b0);
    step(1);
    chk("R5", "cfg 12: lock at 12", lock_det, 1'b1);
    lock_cnt_cfg = 8'd5; win_ok = 1'b0; step(2);
  endtask

  task automatic t_auto();
    alock_use = 1'b0; auto_en = 1'b0;
    win_ok = 1'b1; step(5);
    win_ok = 1'b0; step(3);
    chk("R6", "auto off: no entry", cp_hiz, 1'b0);
    auto_en = 1'b1; win_ok = 1'b1; step(5);
    chk("R5", "locked before loss", lock_det, 1'b1);
    win_ok = 1'b0; step(1);
    chk("R6", "lock drops", lock_det, 1'b0);
    chk("R6", "entry one edge later", cp_hiz, 1'b0);
    step(1);
    // alock_use = 0 with alock_lvl = 0 still counts as high
    chk("R7", "auto entry, analog ignored", cp_hiz, 1'b1);
    step(4);
    chk("R8", "waits for ref edge", cp_hiz, 1'b1);
    pulse_ref();
    chk("R8", "released on ref edge", cp_hiz, 1'b0);
    chk("R8", "bcnt on auto release", bcnt_rst, 1'b1);
    chk("R8", "rearm pending", rearm_pend, 1'b1);
    win_ok = 1'b1; step(2); win_ok = 1'b0; step(3);
    chk("R8", "no retrigger without lock", cp_hiz, 1'b0);
    chk("R8", "still pending", rearm_pend, 1'b1);
    win_ok = 1'b1; step(6);
    chk("R8", "rearm clears after lock", rearm_pend, 1'b0);
  endtask

  task automatic t_alock();
    alock_use = 1'b1; alock_lvl = 1'b0; step(1);
    win_ok = 1'b0; step(3);
    chk("R7", "analog low blocks entry", cp_hiz, 1'b0);
    alock_lvl = 1'b1; step(3);
    win_ok = 1'b1; step(5);
    win_ok = 1'b0; step(2);
    chk("R7", "analog high allows entry", cp_hiz, 1'b1);
    pulse_ref();
    chk("R8", "release again", cp_hiz, 1'b0);
    win_ok = 1'b1; step(6);
    alock_use = 1'b0; auto_en = 1'b0; step(1);
  endtask

  task automatic t_cal();
    cal_req = 1'b1; step(1); cal_req = 1'b0;
    chk("R9", "refused: err", cal_err, 1'b1);
    chk("R9", "refused: no start", cal_start, 1'b0);
    step(1);
    chk("R9", "err single cycle", cal_err, 1'b0);
    hold_en_a = 1'b0; step(1);
    cal_req = 1'b1; step(1); cal_req = 1'b0;
    chk("R9", "accepted: start", cal_start, 1'b1);
    chk("R9", "accepted: no err", cal_err, 1'b0);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_manual();
    t_disable();
    t_lockq();
    t_auto();
    t_alock();
    t_cal();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule